// File: doc/BRIEF.md
# Acknowledgment Start Delay Timer

This block measures the turnaround gap between the moment a received frame finishes and the moment the acknowledgment frame may go out on the air. Time is counted in symbol periods, and a one-cycle strobe from outside the block marks each period. The timer starts only when a reception ends on a frame that asks for an acknowledgment. It then chooses its delay from a short-turnaround bit, a modulation-rate class and the slot mode. The choice is taken when the timer starts.

In unslotted operation the timer times itself out and fires a one-cycle start pulse toward the transmitter. In slotted operation it does not start the acknowledgment on its own. It counts a minimum guard time and then raises an enable flag. After that, a rising edge on the external trigger input produces the start pulse. A trigger that arrives before the guard time has passed is dropped, and the block keeps no memory of it.

Top module: `ackdly_timer`

## Requirements
- R1: While reset is held and on the first cycle after it, `ack_start` and `trig_en` are both 0.
- R2: A `rx_done` pulse with `ack_req` low does not start the timer. It also cancels any timing in progress, so no `ack_start` and no `trig_en` follow until a later `rx_done` that has `ack_req` high.
- R3: Unslotted mode (`slotted`=0) with `short_dly`=0: `ack_start` is high on the cycle after the clock edge that samples the 12th `sym_tick` after the arming edge. A `sym_tick` on the arming edge itself is not counted.
- R4: Unslotted mode with `short_dly`=1 and `rate_hi`=0 (lower-rate class): the start pulse follows the 2nd counted tick.
- R5: Unslotted mode with `short_dly`=1 and `rate_hi`=1 (higher-rate class): the start pulse follows the 3rd counted tick.
- R6: Slotted mode (`slotted`=1): no `ack_start` without a trigger. `trig_en` rises on the cycle after the 6th counted tick when `short_dly`=0, and after the 3rd when `short_dly`=1, whatever `rate_hi` is.
- R7: A trigger that is high or rising while `trig_en` is 0 is ignored and not stored. A trigger level held high across the enable point does not start the transmission. Only a low-to-high change of `ext_trig` seen while `trig_en` is 1 counts.
- R8: While `trig_en` is 1, a rising edge of `ext_trig` (high now, low on the previous cycle) makes `ack_start` high on the next cycle. `trig_en` drops on that same cycle.
- R9: A `rx_done` with `ack_req` high while the timer is counting or waiting for a trigger restarts the count from zero with the configuration sampled at that edge.
- R10: `ack_start` lasts exactly one cycle, and the block then returns to idle. In idle, `sym_tick` and `ext_trig` have no effect.
- R11: `short_dly`, `rate_hi` and `slotted` are sampled on the arming edge. Changing them later does not alter the delay in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_tick | input | 1 | One-cycle strobe per symbol period |
| rx_done | input | 1 | One-cycle pulse at the end of a frame reception |
| ack_req | input | 1 | Received frame requests an acknowledgment; qualifies `rx_done` |
| short_dly | input | 1 | 1 selects the reduced turnaround |
| rate_hi | input | 1 | Modulation class: 0 lower rate, 1 higher rate |
| slotted | input | 1 | 1 selects externally triggered start |
| ext_trig | input | 1 | External transmit trigger (level; rising edge used) |
| ack_start | output | 1 | One-cycle pulse that starts the acknowledgment transmission |
| trig_en | output | 1 | High while slotted mode waits for an external trigger |

## Verification
A wrong tick count or a wrongly chosen limit shows at the ports as an `ack_start` or a `trig_en` edge that comes one or more symbol ticks early or late. This can be seen within at most twelve ticks of the arming pulse. An edge detector that remembers too much or too little shows as a start pulse from a held trigger, or as no start pulse after a clean rising edge, on the cycle right after the trigger. A stuck state shows as a second start pulse, or as `trig_en` staying high after the pulse, on the cycle after the pulse.

// File: rtl/ackdly_pkg.sv
// Package: shared constants and state type for the acknowledgment delay timer.
// Assumes every delay fits the counter width chosen by the top module.
package ackdly_pkg;
    localparam int DLY_STD      = 12; // unslotted, normal turnaround
    localparam int DLY_SHORT_LO = 2;  // unslotted, reduced, lower-rate class
    localparam int DLY_SHORT_HI = 3;  // unslotted, reduced, higher-rate class
    localparam int EN_STD       = 6;  // slotted guard, normal
    localparam int EN_SHORT     = 3;  // slotted guard, reduced

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_WAIT  = 2'd2
    } ackdly_state_t;
endpackage

// File: rtl/ackdly_counter.sv
// Module: symbol-tick counter. Clears on request, advances on an increment
// strobe. Assumes the caller clears it before it could wrap.
module ackdly_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count ticks, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ackdly_limit.sv
// Module: selects the tick count that ends the timing phase from the sampled
// configuration. Purely combinational; assumes all delays fit W bits.
module ackdly_limit
    import ackdly_pkg::*;
#(
    parameter int W         = 4,
    parameter int STD       = DLY_STD,
    parameter int SHORT_LO  = DLY_SHORT_LO,
    parameter int SHORT_HI  = DLY_SHORT_HI,
    parameter int SLOT_STD  = EN_STD,
    parameter int SLOT_SHRT = EN_SHORT
) (
    input  logic         slot,
    input  logic         short_sel,
    input  logic         hi_rate,
    output logic [W-1:0] lim
);
    localparam logic [W-1:0] L_STD  = W'(STD);
    localparam logic [W-1:0] L_LO   = W'(SHORT_LO);
    localparam logic [W-1:0] L_HI   = W'(SHORT_HI);
    localparam logic [W-1:0] L_SSTD = W'(SLOT_STD);
    localparam logic [W-1:0] L_SSH  = W'(SLOT_SHRT);

    // Pick the limit: slotted ignores the rate class.
    always_comb begin
        if (slot)           lim = short_sel ? L_SSH : L_SSTD;
        else if (!short_sel) lim = L_STD;
        else                lim = hi_rate ? L_HI : L_LO;
    end
endmodule

// File: rtl/ackdly_edge.sv
// Module: rising-edge detector for the external trigger. The previous level
// is always tracked, so a level held high yields no edge later.
module ackdly_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic prev,
    output logic rise
);
    // Remember last cycle's trigger level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= din;
    end

    assign rise = din & ~prev;
endmodule

// File: rtl/ackdly_timer.sv
// Module: acknowledgment start delay timer (top). Arms on end of reception
// with an acknowledgment request, counts symbol ticks to a configured limit,
// then either fires the start pulse (unslotted) or enables the external
// trigger (slotted). Assumes sym_tick and rx_done are single-cycle strobes.
module ackdly_timer
    import ackdly_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_tick,
    input  logic rx_done,
    input  logic ack_req,
    input  logic short_dly,
    input  logic rate_hi,
    input  logic slotted,
    input  logic ext_trig,
    output logic ack_start,
    output logic trig_en
);
    ackdly_state_t    st;
    logic             slot_q, short_q, hi_q;
    logic [CNT_W-1:0] cnt, lim;
    logic             trig_prev, trig_rise;
    logic             in_count, is_idle, hit;

    assign in_count = (st == ST_COUNT);
    assign is_idle  = (st == ST_IDLE);
    assign trig_en  = (st == ST_WAIT);
    assign hit      = in_count && sym_tick && (cnt == lim - 1'b1);

    ackdly_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_done || !in_count),
        .inc   (in_count && sym_tick),
        .cnt   (cnt)
    );

    ackdly_limit #(.W(CNT_W)) u_lim (
        .slot      (slot_q),
        .short_sel (short_q),
        .hi_rate   (hi_q),
        .lim       (lim)
    );

    ackdly_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_trig),
        .prev  (trig_prev),
        .rise  (trig_rise)
    );

    // Sequencer: arm/restart/cancel, finish timing, accept trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            ack_start <= 1'b0;
            slot_q    <= 1'b0;
            short_q   <= 1'b0;
            hi_q      <= 1'b0;
        end else begin
            ack_start <= 1'b0;
            if (rx_done) begin
                if (ack_req) begin
                    st      <= ST_COUNT;
                    slot_q  <= slotted;
                    short_q <= short_dly;
                    hi_q    <= rate_hi;
                end else begin
                    st <= ST_IDLE;
                end
            end else begin
                unique case (st)
                    ST_COUNT: if (hit) begin
                        if (slot_q) st <= ST_WAIT;
                        else begin
                            ack_start <= 1'b1;
                            st        <= ST_IDLE;
                        end
                    end
                    ST_WAIT: if (trig_rise) begin
                        ack_start <= 1'b1;
                        st        <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ackdly_chk.sv
// Module: property checker for ackdly_timer, attached with bind.
module ackdly_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_done,
    input logic             ack_req,
    input logic             ext_trig,
    input logic             ack_start,
    input logic             trig_en,
    input logic             trig_prev,
    input logic             slot_q,
    input logic             in_count,
    input logic             is_idle,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] lim
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!ack_start && !trig_en));

    // R2
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && !(rx_done && ack_req)) |=> (!ack_start && !trig_en));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_count |-> (cnt < lim));

    // R7
    slot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_start && slot_q) |-> $past(trig_en));

    // R8
    trig_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && !rx_done && ext_trig && !trig_prev) |=> (ack_start && !trig_en));

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_start |=> !ack_start);

    // R10
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_start |-> !trig_en);
endmodule

bind ackdly_timer ackdly_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_done   (rx_done),
    .ack_req   (ack_req),
    .ext_trig  (ext_trig),
    .ack_start (ack_start),
    .trig_en   (trig_en),
    .trig_prev (trig_prev),
    .slot_q    (slot_q),
    .in_count  (in_count),
    .is_idle   (is_idle),
    .cnt       (cnt),
    .lim       (lim)
);

// File: tb/test_ackdly_timer.sv
// Bench: directed corner cases plus seeded random stimulus, each cycle
// compared against a requirement-level reference model.
module test_ackdly_timer;
    logic clk = 1'b0;
    logic rst_n;
    logic sym_tick, rx_done, ack_req, short_dly, rate_hi, slotted, ext_trig;
    logic ack_start, trig_en;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    // reference model state: 0 idle, 1 counting, 2 waiting for trigger
    int m_st, m_cnt, m_lim;
    bit m_slot, m_prev, m_start;

    always #2 clk = ~clk; // 250 MHz

    ackdly_timer i_ackdly_timer (
        .clk(clk), .rst_n(rst_n), .sym_tick(sym_tick), .rx_done(rx_done),
        .ack_req(ack_req), .short_dly(short_dly), .rate_hi(rate_hi),
        .slotted(slotted), .ext_trig(ext_trig),
        .ack_start(ack_start), .trig_en(trig_en)
    );

    function automatic int lim_f(bit sl, bit sh, bit hi);
        if (sl) return sh ? 3 : 6;     // R6
        if (!sh) return 12;            // R3
        return hi ? 3 : 2;             // R5, R4
    endfunction

    task automatic chk(string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, advance model, compare after the edge.
    task automatic step(bit tk, bit rd, bit ar, bit sh, bit hi, bit sl, bit tg);
        bit rise;
        sym_tick = tk; rx_done = rd; ack_req = ar;
        short_dly = sh; rate_hi = hi; slotted = sl; ext_trig = tg;
        rise = tg && !m_prev;
        m_prev = tg;
        m_start = 1'b0;
        if (rd) begin
            if (ar) begin m_st = 1; m_cnt = 0; m_lim = lim_f(sl, sh, hi); m_slot = sl; end
            else    begin m_st = 0; m_cnt = 0; end
        end else if (m_st == 1) begin
            if (tk) begin
                m_cnt++;
                if (m_cnt == m_lim) begin
                    m_cnt = 0;
                    if (m_slot) m_st = 2;
                    else begin m_st = 0; m_start = 1'b1; end
                end
            end
        end else if (m_st == 2) begin
            if (rise) begin m_st = 0; m_start = 1'b1; end
        end
        @(posedge clk);
        @(negedge clk);
        chk("ack_start", ack_start, m_start);
        chk("trig_en", trig_en, m_st == 2);
    endtask

    task automatic idle_cycles(int n, bit tg);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tg);
    endtask

    // Arm, then tick every cycle for n cycles with config scrambled (R11).
    task automatic arm_run(bit sh, bit hi, bit sl, int n);
        step(1'b1, 1'b1, 1'b1, sh, hi, sl, 1'b0);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, !sh, !hi, !sl, 1'b0);
    endtask

    initial begin
        m_st = 0; m_cnt = 0; m_lim = 12; m_slot = 0; m_prev = 0; m_start = 0;
        rst_n = 1'b0;
        sym_tick = 0; rx_done = 0; ack_req = 0; short_dly = 0;
        rate_hi = 0; slotted = 0; ext_trig = 0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk("ack_start in reset", ack_start, 1'b0);
        chk("trig_en in reset", trig_en, 1'b0);
        rst_n = 1'b1;
        idle_cycles(2, 1'b0);

        cur_req = "R10"; idle_cycles(4, 1'b1); idle_cycles(2, 1'b0);
        cur_req = "R3";  arm_run(1'b0, 1'b0, 1'b0, 14);
        cur_req = "R4";  arm_run(1'b1, 1'b0, 1'b0, 4);
        cur_req = "R5";  arm_run(1'b1, 1'b1, 1'b0, 4);
        cur_req = "R11"; arm_run(1'b1, 1'b1, 1'b0, 5);
        cur_req = "R6";  arm_run(1'b0, 1'b1, 1'b1, 20);
        step(1'b0, 1'b1, 1'b0, 0, 0, 0, 0);            // cancel wait
        cur_req = "R6";  arm_run(1'b1, 1'b0, 1'b1, 6);
        cur_req = "R8";  step(0, 0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 0, 0);

        // R7: trigger pulsed and then held high before the enable point
        cur_req = "R7";
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b1, 0, 0, 0, 0, 0, 1'b0);
        step(1'b1, 0, 0, 0, 0, 0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, 0, 0, 0, 0, 0, 1'b1);
        step(1'b0, 0, 0, 0, 0, 0, 1'b0);
        cur_req = "R8";
        step(1'b0, 0, 0, 0, 0, 0, 1'b1);
        step(1'b0, 0, 0, 0, 0, 0, 1'b1);

        // R9: restart mid-count, then restart from the waiting state
        cur_req = "R9";
        step(1, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0);
        arm_run(1'b1, 1'b0, 1'b1, 4);
        step(1, 1, 1, 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0, 0);

        // R2: end of reception without request, and cancel mid-count
        cur_req = "R2";
        step(1, 1, 0, 1, 0, 0, 0);
        idle_cycles(5, 1'b0);
        step(1, 1, 1, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        idle_cycles(14, 1'b0);

        // Random mix
        cur_req = "R9";
        begin
            int unsigned s;
            s = $urandom(32'd1234);
            for (int i = 0; i < 6000; i++) begin
                step(($urandom % 3) == 0, ($urandom % 40) == 0, ($urandom % 4) != 0,
                     $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 5) == 0);
            end
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL %s watchdog: actual=hung expected=done", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule